// File: doc/BRIEF.md
# Protection Switch Byte and Line Maintenance Monitor

This block watches the two protection switch bytes carried in the line overhead of each received frame. A frame strobe marks the cycle in which an upstream overhead extractor presents the pair for that frame. A new pair is copied into the readable output registers only after it has arrived unchanged in three frames running. A failure flag rises when the first byte cannot hold one value for three frames within a twelve-frame window. Line alarm indication and line remote defect indication are decoded from the low three bits of the second byte, and each is filtered over five frames.

On the transmit side the block picks the outgoing pair either from configuration inputs or from the overhead bytes that arrive with the add data. When automatic remote defect insertion is enabled, the block overwrites the low three bits of the outgoing second byte with the remote defect code. It does this while loss of signal, loss of frame or the detected line alarm is present, and for twenty frames after the last of them clears. The protection switch decision is made elsewhere; this block supplies the filtered bytes and alarms that the decision needs.

Top module: `aps_line_monitor`

## Requirements
- R1: The latched pair (acceptedA, acceptedB) resets to 8'h00 and takes the received pair at the frame strobe on which that identical pair has been seen in three consecutive strobes; otherwise it holds.
- R2: switchFail is set at the twelfth consecutive strobe on which rxApsA has not been identical over the last three strobes, and clears at the first strobe on which it has.
- R3: lineAis is set after five consecutive strobes with rxApsB[2:0] = 3'b111 and cleared after five consecutive strobes with any other value there.
- R4: lineRdi is set after five consecutive strobes with rxApsB[2:0] = 3'b110 and cleared after five consecutive strobes with any other value there.
- R5: With txSrcSel = 0 the transmit pair equals cfgApsA/cfgApsB; with txSrcSel = 1 it equals addApsA/addApsB (subject to R6).
- R6: While autoRdiEn = 1 and any of losIn, lofIn or lineAis is high, txApsB[2:0] = 3'b110 and txApsB[7:3] and txApsA still come from the selected source.
- R7: With autoRdiEn = 1, the forced code of R6 stays on through exactly twenty frame strobes after the last triggering defect goes low.
- R8: With autoRdiEn = 0, the defects have no effect on the transmit pair.
- R9: Changes on rxApsA/rxApsB between frame strobes have no effect on the latched pair or on any alarm flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle strobe per received frame; receive bytes valid in that cycle |
| rxApsA | input | 8 | First received protection switch byte |
| rxApsB | input | 8 | Second received protection switch byte |
| losIn | input | 1 | Loss of signal defect |
| lofIn | input | 1 | Loss of frame defect |
| autoRdiEn | input | 1 | Enables automatic remote defect insertion |
| txSrcSel | input | 1 | Transmit source: 0 configuration, 1 add-side overhead |
| cfgApsA | input | 8 | Configured first transmit byte |
| cfgApsB | input | 8 | Configured second transmit byte |
| addApsA | input | 8 | First byte from add-side overhead |
| addApsB | input | 8 | Second byte from add-side overhead |
| acceptedA | output | 8 | Latched first byte |
| acceptedB | output | 8 | Latched second byte |
| switchFail | output | 1 | Protection switch failure alarm |
| lineAis | output | 1 | Line alarm indication detected |
| lineRdi | output | 1 | Line remote defect indication detected |
| txApsA | output | 8 | First transmit byte |
| txApsB | output | 8 | Second transmit byte |

## Verification
The bench builds the block with its default parameters: three-frame acceptance, a twelve-frame failure window, five-frame defect filtering and a twenty-frame hold. These values are small enough to sweep every one of the eight line status codes against every run length from one to six frames. They also let the bench walk the failure window past its limit and count the whole hold period, strobe by strobe, for each of the three defect sources.

// File: rtl/aps_mon_pkg.sv
package aps_mon_pkg;

  localparam logic [2:0] AIS_CODE = 3'b111;
  localparam logic [2:0] RDI_CODE = 3'b110;

  // strobes from control to datapath
  typedef struct packed {
    logic latchPair;
    logic failSet;
    logic failClr;
    logic aisToggle;
    logic rdiToggle;
    logic forceRdi;
  } ctlStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic pairSame;
    logic aSame;
    logic aisCode;
    logic rdiCode;
    logic aisNow;
    logic rdiNow;
  } dpObs_t;

endpackage

// File: rtl/aps_mon_ctrl.sv
module aps_mon_ctrl
  import aps_mon_pkg::*;
#(
  parameter int ACCEPT_N    = 3,
  parameter int FAIL_WINDOW = 12,
  parameter int DEF_N       = 5,
  parameter int RDI_HOLD    = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       losIn,
  input  logic       lofIn,
  input  logic       autoRdiEn,
  input  dpObs_t     obs,
  output ctlStrobe_t ctl
);

  localparam int ACW = $clog2(ACCEPT_N + 1);
  localparam int WW  = $clog2(FAIL_WINDOW + 1);
  localparam int DW  = $clog2(DEF_N + 1);
  localparam int HW  = $clog2(RDI_HOLD + 1);

  // run-length counters: index 0 whole pair, index 1 first byte
  logic [1:0] runSame;
  logic [1:0] runDone;

  assign runSame = {obs.aSame, obs.pairSame};

  for (genvar g = 0; g < 2; g++) begin : gRun
    logic [ACW-1:0] cnt;
    logic [ACW-1:0] cntNext;

    always_comb begin
      if (!runSame[g])
        cntNext = ACW'(1);
      else if (cnt >= ACW'(ACCEPT_N))
        cntNext = cnt;
      else
        cntNext = cnt + ACW'(1);
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        cnt <= '0;
      else if (frameStb)
        cnt <= cntNext;
    end

    assign runDone[g] = frameStb && (cntNext >= ACW'(ACCEPT_N));
  end

  // failure window on the first byte
  logic [WW-1:0] winCnt;
  logic          aStable;

  assign aStable = runDone[1];

  always_ff @(posedge clk) begin
    if (!rstN)
      winCnt <= '0;
    else if (frameStb) begin
      if (aStable)
        winCnt <= '0;
      else if (winCnt < WW'(FAIL_WINDOW))
        winCnt <= winCnt + WW'(1);
    end
  end

  // five-frame persistency: index 0 alarm indication, index 1 remote defect
  logic [1:0] codeMatch;
  logic [1:0] flagNow;
  logic [1:0] flagToggle;

  assign codeMatch = {obs.rdiCode, obs.aisCode};
  assign flagNow   = {obs.rdiNow, obs.aisNow};

  for (genvar g = 0; g < 2; g++) begin : gPersist
    logic [DW-1:0] cnt;
    logic          differs;

    assign differs = codeMatch[g] != flagNow[g];

    always_ff @(posedge clk) begin
      if (!rstN)
        cnt <= '0;
      else if (frameStb) begin
        if (!differs || cnt >= DW'(DEF_N - 1))
          cnt <= '0;
        else
          cnt <= cnt + DW'(1);
      end
    end

    assign flagToggle[g] = frameStb && differs && (cnt >= DW'(DEF_N - 1));
  end

  // remote defect hold-off
  logic [HW-1:0] holdCnt;
  logic          defectNow;

  assign defectNow = losIn || lofIn || obs.aisNow;

  always_ff @(posedge clk) begin
    if (!rstN)
      holdCnt <= '0;
    else if (defectNow)
      holdCnt <= HW'(RDI_HOLD);
    else if (frameStb && holdCnt != '0)
      holdCnt <= holdCnt - HW'(1);
  end

  always_comb begin
    ctl.latchPair = runDone[0];
    ctl.failSet   = frameStb && !aStable && (winCnt >= WW'(FAIL_WINDOW - 1));
    ctl.failClr   = aStable;
    ctl.aisToggle = flagToggle[0];
    ctl.rdiToggle = flagToggle[1];
    ctl.forceRdi  = autoRdiEn && (defectNow || holdCnt != '0);
  end

endmodule

// File: rtl/aps_mon_dpath.sv
module aps_mon_dpath
  import aps_mon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [BYTE_W-1:0] rxApsA,
  input  logic [BYTE_W-1:0] rxApsB,
  input  logic              txSrcSel,
  input  logic [BYTE_W-1:0] cfgApsA,
  input  logic [BYTE_W-1:0] cfgApsB,
  input  logic [BYTE_W-1:0] addApsA,
  input  logic [BYTE_W-1:0] addApsB,
  input  ctlStrobe_t        ctl,
  output dpObs_t            obs,
  output logic [BYTE_W-1:0] acceptedA,
  output logic [BYTE_W-1:0] acceptedB,
  output logic              switchFail,
  output logic              lineAis,
  output logic              lineRdi,
  output logic [BYTE_W-1:0] txApsA,
  output logic [BYTE_W-1:0] txApsB
);

  logic [BYTE_W-1:0] prevA;
  logic [BYTE_W-1:0] prevB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= '0;
      prevB <= '0;
    end else if (frameStb) begin
      prevA <= rxApsA;
      prevB <= rxApsB;
    end
  end

  always_comb begin
    obs.aSame    = rxApsA == prevA;
    obs.pairSame = (rxApsA == prevA) && (rxApsB == prevB);
    obs.aisCode  = rxApsB[2:0] == AIS_CODE;
    obs.rdiCode  = rxApsB[2:0] == RDI_CODE;
    obs.aisNow   = lineAis;
    obs.rdiNow   = lineRdi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptedA <= '0;
      acceptedB <= '0;
    end else if (ctl.latchPair) begin
      acceptedA <= rxApsA;
      acceptedB <= rxApsB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      switchFail <= 1'b0;
      lineAis    <= 1'b0;
      lineRdi    <= 1'b0;
    end else begin
      if (ctl.failSet)
        switchFail <= 1'b1;
      else if (ctl.failClr)
        switchFail <= 1'b0;
      lineAis <= lineAis ^ ctl.aisToggle;
      lineRdi <= lineRdi ^ ctl.rdiToggle;
    end
  end

  // transmit source and remote defect overwrite
  logic [BYTE_W-1:0] srcA;
  logic [BYTE_W-1:0] srcB;

  always_comb begin
    srcA   = txSrcSel ? addApsA : cfgApsA;
    srcB   = txSrcSel ? addApsB : cfgApsB;
    txApsA = srcA;
    txApsB = ctl.forceRdi ? {srcB[BYTE_W-1:3], RDI_CODE} : srcB;
  end

endmodule

// File: rtl/aps_line_monitor.sv
module aps_line_monitor
  import aps_mon_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ACCEPT_N    = 3,
  parameter int FAIL_WINDOW = 12,
  parameter int DEF_N       = 5,
  parameter int RDI_HOLD    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [BYTE_W-1:0] rxApsA,
  input  logic [BYTE_W-1:0] rxApsB,
  input  logic              losIn,
  input  logic              lofIn,
  input  logic              autoRdiEn,
  input  logic              txSrcSel,
  input  logic [BYTE_W-1:0] cfgApsA,
  input  logic [BYTE_W-1:0] cfgApsB,
  input  logic [BYTE_W-1:0] addApsA,
  input  logic [BYTE_W-1:0] addApsB,
  output logic [BYTE_W-1:0] acceptedA,
  output logic [BYTE_W-1:0] acceptedB,
  output logic              switchFail,
  output logic              lineAis,
  output logic              lineRdi,
  output logic [BYTE_W-1:0] txApsA,
  output logic [BYTE_W-1:0] txApsB
);

  ctlStrobe_t ctl;
  dpObs_t     obs;

  aps_mon_ctrl #(
    .ACCEPT_N   (ACCEPT_N),
    .FAIL_WINDOW(FAIL_WINDOW),
    .DEF_N      (DEF_N),
    .RDI_HOLD   (RDI_HOLD)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameStb (frameStb),
    .losIn    (losIn),
    .lofIn    (lofIn),
    .autoRdiEn(autoRdiEn),
    .obs      (obs),
    .ctl      (ctl)
  );

  aps_mon_dpath #(
    .BYTE_W(BYTE_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .frameStb  (frameStb),
    .rxApsA    (rxApsA),
    .rxApsB    (rxApsB),
    .txSrcSel  (txSrcSel),
    .cfgApsA   (cfgApsA),
    .cfgApsB   (cfgApsB),
    .addApsA   (addApsA),
    .addApsB   (addApsB),
    .ctl       (ctl),
    .obs       (obs),
    .acceptedA (acceptedA),
    .acceptedB (acceptedB),
    .switchFail(switchFail),
    .lineAis   (lineAis),
    .lineRdi   (lineRdi),
    .txApsA    (txApsA),
    .txApsB    (txApsB)
  );

endmodule

// File: rtl/aps_line_monitor_chk.sv
module aps_line_monitor_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStb,
  input logic [BYTE_W-1:0] rxApsA,
  input logic [BYTE_W-1:0] rxApsB,
  input logic              losIn,
  input logic              autoRdiEn,
  input logic              txSrcSel,
  input logic [BYTE_W-1:0] cfgApsB,
  input logic [BYTE_W-1:0] acceptedA,
  input logic [BYTE_W-1:0] acceptedB,
  input logic              switchFail,
  input logic              lineAis,
  input logic              lineRdi,
  input logic [BYTE_W-1:0] txApsB
);

  // R1
  latch_from_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(acceptedB) |-> ($past(frameStb) && acceptedB == $past(rxApsB)));

  // R9
  latch_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(acceptedA) |-> $past(frameStb));

  // R2
  fail_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchFail) |-> $past(frameStb));

  // R3
  ais_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineAis) |-> ($past(frameStb) && $past(rxApsB[2:0]) == 3'b111));

  // R4
  rdi_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineRdi) |-> ($past(frameStb) && $past(rxApsB[2:0]) == 3'b110));

  // R3
  ais_rdi_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lineAis && lineRdi));

  // R6
  auto_rdi_los_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoRdiEn && losIn) |-> (txApsB[2:0] == 3'b110));

  // R8
  no_force_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!autoRdiEn && !txSrcSel) |-> (txApsB == cfgApsB));

endmodule

bind aps_line_monitor aps_line_monitor_chk #(.BYTE_W(BYTE_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .frameStb  (frameStb),
  .rxApsA    (rxApsA),
  .rxApsB    (rxApsB),
  .losIn     (losIn),
  .autoRdiEn (autoRdiEn),
  .txSrcSel  (txSrcSel),
  .cfgApsB   (cfgApsB),
  .acceptedA (acceptedA),
  .acceptedB (acceptedB),
  .switchFail(switchFail),
  .lineAis   (lineAis),
  .lineRdi   (lineRdi),
  .txApsB    (txApsB)
);

// File: tb/sim_aps_line_monitor.sv
`timescale 1ns/1ps
module sim_aps_line_monitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStb = 1'b0;
  logic [7:0] rxApsA = '0, rxApsB = '0;
  logic       losIn = 1'b0, lofIn = 1'b0, autoRdiEn = 1'b0, txSrcSel = 1'b0;
  logic [7:0] cfgApsA = '0, cfgApsB = '0, addApsA = '0, addApsB = '0;
  logic [7:0] acceptedA, acceptedB, txApsA, txApsB;
  logic       switchFail, lineAis, lineRdi;

  always #10 clk = ~clk;

  aps_line_monitor u0 (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [7:0] hA [5];
  logic [7:0] hB [5];
  int   nFrames = 0;
  logic [7:0] eAccA = '0, eAccB = '0;
  logic eFail = 0, eAis = 0, eRdi = 0;
  int   sinceStable = 0;
  int   hold = 0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkTx(string tag);
    logic [7:0] sA, sB, eB;
    logic force_;
    sA = txSrcSel ? addApsA : cfgApsA;
    sB = txSrcSel ? addApsB : cfgApsB;
    force_ = autoRdiEn && (losIn || lofIn || eAis || hold > 0);
    eB = force_ ? {sB[7:3], 3'b110} : sB;
    check({tag, " txA"}, {8'h0, txApsA}, {8'h0, sA});
    check({tag, " txB"}, {8'h0, txApsB}, {8'h0, eB});
  endtask

  task automatic checkAll(string txTag);
    check("R1 accepted", {acceptedA, acceptedB}, {eAccA, eAccB});
    check("R2 switchFail", {15'h0, switchFail}, {15'h0, eFail});
    check("R3 lineAis", {15'h0, lineAis}, {15'h0, eAis});
    check("R4 lineRdi", {15'h0, lineRdi}, {15'h0, eRdi});
    checkTx(txTag);
  endtask

  task automatic sendFrame(logic [7:0] a, logic [7:0] b, string txTag);
    logic aisBefore, aSt, allAis, noAis, allRdi, noRdi;
    @(negedge clk);
    rxApsA = a; rxApsB = b; frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    aisBefore = eAis;
    for (int i = 4; i > 0; i--) begin hA[i] = hA[i-1]; hB[i] = hB[i-1]; end
    hA[0] = a; hB[0] = b;
    nFrames++;
    aSt = nFrames >= 3 && hA[0] == hA[1] && hA[1] == hA[2];
    if (aSt && hB[0] == hB[1] && hB[1] == hB[2]) begin eAccA = a; eAccB = b; end
    if (aSt) begin sinceStable = 0; eFail = 0; end
    else begin sinceStable++; if (sinceStable >= 12) eFail = 1; end
    allAis = nFrames >= 5; noAis = nFrames >= 5;
    allRdi = nFrames >= 5; noRdi = nFrames >= 5;
    for (int i = 0; i < 5; i++) begin
      if (hB[i][2:0] != 3'b111) allAis = 0; else noAis = 0;
      if (hB[i][2:0] != 3'b110) allRdi = 0; else noRdi = 0;
    end
    if (!eAis && allAis) eAis = 1; else if (eAis && noAis) eAis = 0;
    if (!eRdi && allRdi) eRdi = 1; else if (eRdi && noRdi) eRdi = 0;
    if (losIn || lofIn || aisBefore) hold = 20;
    else if (hold > 0) hold--;
    #1;
    checkAll(txTag);
  endtask

  task automatic setDefects(logic los, logic lof);
    @(negedge clk);
    losIn = los; lofIn = lof;
    if (los || lof) hold = 20;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin hA[i] = '0; hB[i] = '0; end
    repeat (3) @(negedge clk);
    // reset state
    #1;
    check("R1 reset accepted", {acceptedA, acceptedB}, 16'h0000);
    check("R2 reset fail", {15'h0, switchFail}, 16'h0);
    check("R3 reset ais", {15'h0, lineAis}, 16'h0);
    check("R4 reset rdi", {15'h0, lineRdi}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    cfgApsA = 8'hA5; cfgApsB = 8'h3C; addApsA = 8'h5A; addApsB = 8'hC1;
    #1;
    checkTx("R5");

    // R1: run lengths one to four of a fresh pair
    for (int run = 1; run <= 4; run++)
      for (int k = 0; k < run; k++)
        sendFrame(8'(run * 16 + 1), 8'(run * 8 + 2), "R5");

    // R9: receive bytes move with no strobe
    @(negedge clk);
    rxApsA = 8'hEE; rxApsB = 8'h07;
    repeat (4) @(negedge clk);
    #1;
    check("R9 accepted held", {acceptedA, acceptedB}, {eAccA, eAccB});
    check("R9 ais held", {15'h0, lineAis}, {15'h0, eAis});
    check("R9 fail held", {15'h0, switchFail}, {15'h0, eFail});

    // R2: first byte keeps changing, then settles
    for (int i = 0; i < 14; i++) sendFrame(8'(i + 100), 8'h10, "R5");
    for (int i = 0; i < 3; i++) sendFrame(8'h42, 8'h10, "R5");
    for (int i = 0; i < 2; i++) sendFrame(8'(i + 7), 8'h10, "R5");

    // R3 R4: every code against run lengths one to six
    for (int code = 0; code < 8; code++)
      for (int run = 1; run <= 6; run++) begin
        for (int k = 0; k < run; k++) sendFrame(8'h42, 8'(8'h20 | code), "R5");
        for (int k = 0; k < 6; k++) sendFrame(8'h42, 8'h21, "R5");
      end

    // R5: source selection sweep
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 4; v++) begin
        @(negedge clk);
        txSrcSel = s[0];
        cfgApsA = 8'(v * 37); cfgApsB = 8'(v * 53 + 1);
        addApsA = 8'(v * 29 + 3); addApsB = 8'(v * 71 + 5);
        #1;
        checkTx("R5");
      end

    // R6 R7: loss of signal, then hold
    @(negedge clk); autoRdiEn = 1'b1; txSrcSel = 1'b0;
    setDefects(1'b1, 1'b0);
    checkTx("R6");
    sendFrame(8'h42, 8'h21, "R6");
    sendFrame(8'h42, 8'h21, "R6");
    setDefects(1'b0, 1'b0);
    for (int i = 0; i < 22; i++) sendFrame(8'h42, 8'h21, "R7");
    // loss of frame
    setDefects(1'b0, 1'b1);
    checkTx("R6");
    sendFrame(8'h42, 8'h21, "R6");
    setDefects(1'b0, 1'b0);
    for (int i = 0; i < 22; i++) sendFrame(8'h42, 8'h21, "R7");
    // detected line alarm as trigger
    txSrcSel = 1'b1;
    for (int i = 0; i < 6; i++) sendFrame(8'h42, 8'h27, "R6");
    for (int i = 0; i < 27; i++) sendFrame(8'h42, 8'h21, "R7");

    // R8: defects with insertion disabled
    @(negedge clk); autoRdiEn = 1'b0;
    setDefects(1'b1, 1'b1);
    checkTx("R8");
    for (int i = 0; i < 3; i++) sendFrame(8'h42, 8'h21, "R8");
    for (int i = 0; i < 6; i++) sendFrame(8'h42, 8'h27, "R8");
    setDefects(1'b0, 1'b0);
    checkTx("R8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule